// File: doc/BRIEF.md
# HDLC/LAPS Transmit Frame Encapsulator

This block turns a byte-wide packet stream, marked with start and end flags, into a byte-stuffed HDLC octet stream ready for a SONET/SDH payload. On request it places a provisioned address octet and control octet ahead of each packet. It appends a 32-bit frame check sequence unless the source already supplies one. It escapes any octet that would look like a flag or an escape, and it sends flags whenever no frame is open.

In LAPS mode the block does not stall when the source runs dry in the middle of a frame. It sends a programmable two-octet rate-adaptation pair instead. In plain HDLC mode the same underrun makes the output valid signal drop for that cycle. A self-synchronous x^43+1 scrambler can be switched onto the final octet stream. The sink throttles the block with a ready signal. The source sees a ready that follows both that signal and the escape timing.

Top module: `hdlc_laps_tx`

## Requirements
- R1: After reset, while no packet start is offered, every output octet is the flag 0x7E with out_valid high, and in_ready is low.
- R2: When cfg_hdr_en is 1, the octets cfg_addr and then cfg_ctl open every frame, ahead of the first packet octet.
- R3: When cfg_ext_fcs is 0, a 4-octet FCS follows the packet octets. It is a CRC-32 with polynomial 0x04C11DB7 and preset all ones, taken over the header and packet octets, each octet fed most significant bit first. The result is complemented and sent least significant octet first.
- R4: When cfg_ext_fcs is 1, no FCS is added, and the frame content equals the header plus the packet octets exactly.
- R5: Inside a frame, any header, packet or FCS octet equal to 0x7E or 0x7D is sent as 0x7D followed by the octet XOR 0x20. No other octet is changed.
- R6: An input octet is taken in a cycle where in_valid and in_ready are both high. in_ready is high in the cycle that sends the leading 0x7D of an escape pair and low in the cycle that sends its second octet.
- R7: A frame starts only after a flag, when in_sop is offered while no frame is open. A flag follows the last octet of every frame, so each packet yields exactly one frame.
- R8: With cfg_laps_en at 1 and no input octet ready inside an open frame, the block sends cfg_ra_pair[15:8] and then cfg_ra_pair[7:0]. The pair is not escaped and is not counted in the FCS.
- R9: The rate-adaptation pair is whatever cfg_ra_pair holds (0x7DDD being the usual value). A different value such as 0x7DCC appears on the output unchanged.
- R10: With cfg_laps_en at 0 and no input octet ready inside an open frame, out_valid is low for that cycle.
- R11: With cfg_scr_en at 1, each output bit equals the unscrambled bit XOR the output bit sent 43 bit times earlier. Bits go out most significant first within each octet, and the history is zero after reset.
- R12: While out_ready is low, out_valid and out_data hold their values, and no state advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hdr_en | input | 1 | Insert address and control octets |
| cfg_addr | input | 8 | Address octet value |
| cfg_ctl | input | 8 | Control octet value |
| cfg_ext_fcs | input | 1 | Source supplies its own FCS; none is added |
| cfg_laps_en | input | 1 | LAPS rate adaptation on underrun |
| cfg_ra_pair | input | 16 | Rate-adaptation pair, high octet sent first |
| cfg_scr_en | input | 1 | Enable x^43+1 output scrambler |
| in_valid | input | 1 | Input octet present |
| in_data | input | 8 | Input octet |
| in_sop | input | 1 | Input octet is the first of a packet |
| in_eop | input | 1 | Input octet is the last of a packet |
| in_ready | output | 1 | Block takes the input octet this cycle |
| out_valid | output | 1 | Output octet present |
| out_data | output | 8 | Output octet |
| out_ready | input | 1 | Sink accepts the output octet |

## Verification
Several kinds of packet are sent through the block and then recovered from the output by a descrambler and a deframer: random octets, packets made only of 0x7E, packets made only of 0x7D, alternating 0x7E/0x7D, and an incrementing count. Random packets show that the FCS and header go in correctly. The all-flag and all-escape packets show that escaping is complete and that the deframer stays aligned. The alternating packets catch escape-state errors that build up from one octet to the next. These runs are repeated with forced source gaps in the middle of frames and with sink backpressure. This separates the LAPS rate-adaptation insertion from the plain HDLC stall, and confirms that escape pairs survive a stalled sink. Directed cycle-exact tests then pin down the ready timing of an escape pair, a custom rate-adaptation value and the idle state after reset.

// File: rtl/hdlc_tx_pkg.sv
`timescale 1ns/1ps
package hdlc_tx_pkg;

    localparam int          OCT_W     = 8;
    localparam int          FCS_W     = 32;
    localparam int          FCS_BYTES = FCS_W / OCT_W;
    localparam logic [7:0]  FLAG_OCT  = 8'h7E;
    localparam logic [7:0]  ESC_OCT   = 8'h7D;
    localparam logic [7:0]  ESC_XOR   = 8'h20;
    localparam logic [31:0] FCS_POLY  = 32'h04C11DB7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CTL,
        ST_DATA,
        ST_RA2,
        ST_FCS
    } tx_state_e;

    // octet offered by the frame sequencer to the stuffer
    typedef struct packed {
        logic       vld;
        logic       transp;   // subject to escaping
        logic [7:0] oct;
    } raw_oct_t;

    typedef struct packed {
        logic        hdr_en;
        logic        ext_fcs;
        logic        laps_en;
        logic        scr_en;
        logic [7:0]  addr;
        logic [7:0]  ctl;
        logic [15:0] ra_pair;
    } tx_cfg_t;

    function automatic logic [31:0] fcs_step(logic [31:0] c, logic [7:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int k = 7; k >= 0; k--) begin
            fb = r[31] ^ d[k];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ FCS_POLY;
        end
        return r;
    endfunction

    function automatic logic is_reserved(logic [7:0] b);
        return (b == FLAG_OCT) || (b == ESC_OCT);
    endfunction

endpackage

// File: rtl/hdlc_fcs_acc.sv
`timescale 1ns/1ps
module hdlc_fcs_acc
    import hdlc_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             upd,
    input  logic [OCT_W-1:0] din,
    output logic [FCS_W-1:0] crc_next
);
    logic [FCS_W-1:0] crc_q;

    assign crc_next = fcs_step(crc_q, din);

    always_ff @(posedge clk) begin
        if (rst || init) crc_q <= '1;
        else if (upd)    crc_q <= crc_next;
    end
endmodule

// File: rtl/hdlc_frame_seq.sv
`timescale 1ns/1ps
module hdlc_frame_seq
    import hdlc_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  tx_cfg_t          cfg,
    input  logic             in_valid,
    input  logic [OCT_W-1:0] in_data,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic             take,
    input  logic [FCS_W-1:0] crc_next,
    output raw_oct_t         raw,
    output tx_state_e        st,
    output logic             fcs_init,
    output logic             fcs_upd
);
    localparam int CNT_W = $clog2(FCS_BYTES);

    tx_state_e        st_q;
    logic [FCS_W-1:0] fcs_sh;
    logic [CNT_W-1:0] fcs_cnt;

    assign st = st_q;

    always_comb begin
        raw = '0;
        unique case (st_q)
            ST_IDLE: raw = '{vld: 1'b1, transp: 1'b0, oct: FLAG_OCT};
            ST_ADDR: raw = '{vld: 1'b1, transp: 1'b1, oct: cfg.addr};
            ST_CTL:  raw = '{vld: 1'b1, transp: 1'b1, oct: cfg.ctl};
            ST_DATA: begin
                if (in_valid)         raw = '{vld: 1'b1, transp: 1'b1, oct: in_data};
                else if (cfg.laps_en) raw = '{vld: 1'b1, transp: 1'b0, oct: cfg.ra_pair[15:8]};
                else                  raw = '0;
            end
            ST_RA2:  raw = '{vld: 1'b1, transp: 1'b0, oct: cfg.ra_pair[7:0]};
            ST_FCS:  raw = '{vld: 1'b1, transp: 1'b1, oct: fcs_sh[OCT_W-1:0]};
            default: raw = '0;
        endcase
    end

    assign fcs_init = take && (st_q == ST_IDLE);
    assign fcs_upd  = take && raw.transp && (st_q != ST_FCS);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            fcs_sh  <= '0;
            fcs_cnt <= '0;
        end else if (take) begin
            unique case (st_q)
                ST_IDLE: if (in_valid && in_sop) st_q <= cfg.hdr_en ? ST_ADDR : ST_DATA;
                ST_ADDR: st_q <= ST_CTL;
                ST_CTL:  st_q <= ST_DATA;
                ST_DATA: begin
                    if (!in_valid) begin
                        st_q <= ST_RA2;
                    end else if (in_eop) begin
                        if (cfg.ext_fcs) begin
                            st_q <= ST_IDLE;
                        end else begin
                            st_q    <= ST_FCS;
                            fcs_sh  <= ~crc_next;
                            fcs_cnt <= '0;
                        end
                    end
                end
                ST_RA2:  st_q <= ST_DATA;
                ST_FCS: begin
                    fcs_sh  <= fcs_sh >> OCT_W;
                    fcs_cnt <= fcs_cnt + 1'b1;
                    if (fcs_cnt == CNT_W'(FCS_BYTES - 1)) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R8: the second rate-adaptation octet only ever follows the first
    assert_ra_order_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == ST_RA2) |-> ($past(raw.oct) == $past(cfg.ra_pair[15:8])));

    // R3: FCS phase is entered only from the packet phase
    assert_fcs_entry_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == ST_FCS) |-> ($past(st_q) == ST_DATA));
endmodule

// File: rtl/hdlc_octet_stuffer.sv
`timescale 1ns/1ps
module hdlc_octet_stuffer
    import hdlc_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  raw_oct_t         raw,
    input  logic             out_ready,
    output logic             up_ready,
    output logic             pend,
    output logic             out_vld,
    output logic [OCT_W-1:0] out_oct
);
    logic [OCT_W-1:0] hold;
    logic             need;

    assign need     = raw.transp && is_reserved(raw.oct);
    assign up_ready = out_ready && !pend;
    assign out_vld  = pend || raw.vld;
    assign out_oct  = pend ? hold : (need ? ESC_OCT : raw.oct);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            hold <= '0;
        end else if (pend) begin
            if (out_ready) pend <= 1'b0;
        end else if (up_ready && raw.vld && need) begin
            pend <= 1'b1;
            hold <= raw.oct ^ ESC_XOR;
        end
    end

    // R5: an escape pair always begins with the escape octet
    assert_esc_lead_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> ($past(out_oct) == ESC_OCT));

    // R5: the second octet of a pair is never itself reserved
    assert_esc_tail_R5: assert property (@(posedge clk) disable iff (rst)
        pend |-> !is_reserved(hold));

    // R12: a stalled pair keeps its second octet
    assert_esc_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (pend && !out_ready) |=> (pend && $stable(hold)));
endmodule

// File: rtl/hdlc_scr_x43.sv
`timescale 1ns/1ps
module hdlc_scr_x43
    import hdlc_tx_pkg::*;
#(
    parameter int LEN = 43
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             vld,
    input  logic             rdy,
    input  logic [OCT_W-1:0] in_oct,
    output logic [OCT_W-1:0] out_oct
);
    localparam int KEEP = LEN - OCT_W;

    logic [LEN-1:0] hist;

    assign out_oct = en ? (in_oct ^ hist[LEN-1 -: OCT_W]) : in_oct;

    always_ff @(posedge clk) begin
        if (rst)             hist <= '0;
        else if (vld && rdy) hist <= {hist[KEEP-1:0], out_oct};
    end

    // R11: with scrambling off the history records the plain octets
    assert_hist_plain_R11: assert property (@(posedge clk) disable iff (rst)
        (!en && vld && rdy) |=> (hist[OCT_W-1:0] == $past(in_oct)));
endmodule

// File: rtl/hdlc_laps_tx.sv
`timescale 1ns/1ps
module hdlc_laps_tx
    import hdlc_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_hdr_en,
    input  logic [7:0]  cfg_addr,
    input  logic [7:0]  cfg_ctl,
    input  logic        cfg_ext_fcs,
    input  logic        cfg_laps_en,
    input  logic [15:0] cfg_ra_pair,
    input  logic        cfg_scr_en,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_sop,
    input  logic        in_eop,
    output logic        in_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    input  logic        out_ready
);
    tx_cfg_t          cfg;
    raw_oct_t         raw;
    tx_state_e        seq_st;
    logic             fcs_init, fcs_upd, take, up_ready, stf_pend;
    logic [FCS_W-1:0] crc_next;
    logic [OCT_W-1:0] stf_oct;

    assign cfg = '{hdr_en: cfg_hdr_en, ext_fcs: cfg_ext_fcs, laps_en: cfg_laps_en,
                   scr_en: cfg_scr_en, addr: cfg_addr, ctl: cfg_ctl, ra_pair: cfg_ra_pair};

    assign take     = up_ready && raw.vld;
    assign in_ready = (seq_st == ST_DATA) && up_ready;

    hdlc_frame_seq u_seq (
        .clk(clk), .rst(rst), .cfg(cfg),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .take(take), .crc_next(crc_next), .raw(raw), .st(seq_st),
        .fcs_init(fcs_init), .fcs_upd(fcs_upd)
    );

    hdlc_fcs_acc u_fcs (
        .clk(clk), .rst(rst), .init(fcs_init), .upd(fcs_upd),
        .din(raw.oct), .crc_next(crc_next)
    );

    hdlc_octet_stuffer u_stf (
        .clk(clk), .rst(rst), .raw(raw), .out_ready(out_ready),
        .up_ready(up_ready), .pend(stf_pend), .out_vld(out_valid), .out_oct(stf_oct)
    );

    hdlc_scr_x43 #(.LEN(43)) u_scr (
        .clk(clk), .rst(rst), .en(cfg_scr_en), .vld(out_valid), .rdy(out_ready),
        .in_oct(stf_oct), .out_oct(out_data)
    );

    // R1: between frames the line carries flags
    assert_idle_flag_R1: assert property (@(posedge clk) disable iff (rst)
        (seq_st == ST_IDLE && !stf_pend && !cfg_scr_en) |-> (out_valid && out_data == FLAG_OCT));

    // R10: plain HDLC mode stalls on an underrun inside a frame
    assert_hdlc_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (!cfg_laps_en && seq_st == ST_DATA && !in_valid && !stf_pend) |-> !out_valid);

    // R6: no input is taken while the second octet of a pair goes out
    assert_pair_noready_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(stf_pend) && out_ready) |-> !in_ready);
endmodule

// File: tb/tb_hdlc_laps_tx.sv
`timescale 1ns/1ps
module tb_hdlc_laps_tx;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_hdr_en, cfg_ext_fcs, cfg_laps_en, cfg_scr_en;
    logic [7:0]  cfg_addr, cfg_ctl;
    logic [15:0] cfg_ra_pair;
    logic        in_valid, in_sop, in_eop, in_ready;
    logic [7:0]  in_data;
    logic        out_valid, out_ready;
    logic [7:0]  out_data;

    always #2 clk = ~clk;

    hdlc_laps_tx dut (
        .clk(clk), .rst(rst), .cfg_hdr_en(cfg_hdr_en), .cfg_addr(cfg_addr), .cfg_ctl(cfg_ctl),
        .cfg_ext_fcs(cfg_ext_fcs), .cfg_laps_en(cfg_laps_en), .cfg_ra_pair(cfg_ra_pair),
        .cfg_scr_en(cfg_scr_en), .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
        .in_eop(in_eop), .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    // fields: seed[31:24] bp[16] ur[15] scr[14] laps[13] ext[12] hdr[11] kind[10:8] len[7:0]
    // kind: 0 random, 1 all 0x7E, 2 all 0x7D, 3 alternating 0x7E/0x7D, 4 incrementing
    localparam int NVEC = 10;
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd3,  7'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 8'd16},
        {8'd4,  7'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 8'd20},
        {8'd5,  7'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd2, 8'd20},
        {8'd6,  7'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 8'd33},
        {8'd7,  7'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 8'd40},
        {8'd8,  7'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'd1},
        {8'd9,  7'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 8'd50},
        {8'd10, 7'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd4, 8'd24},
        {8'd11, 7'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'd30},
        {8'd13, 7'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 8'd64}
    };

    logic [7:0] pkt    [256];
    logic [7:0] stream [8192];
    logic [7:0] ds     [8192];
    logic [7:0] fb     [512];
    logic [7:0] expc   [512];
    int plen, slen, flen, nfr, ra_cnt;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] crc_b(logic [31:0] c, logic [7:0] d);
        logic [31:0] r;
        logic        f;
        r = c;
        for (int k = 7; k >= 0; k--) begin
            f = r[31] ^ d[k];
            r = {r[30:0], 1'b0};
            if (f) r = r ^ 32'h04C11DB7;
        end
        return r;
    endfunction

    task automatic do_reset();
        rst = 1'b1; in_valid = 0; in_sop = 0; in_eop = 0; in_data = 0; out_ready = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_packet(input bit bp, input bit ur);
        int ptr;
        int idle;
        ptr = 0; idle = 0; slen = 0;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            out_ready = !(bp && (c % 5 == 2));
            if (ptr < plen && !(ur && (c % 7 == 3) && ptr > 0)) begin
                in_valid = 1; in_data = pkt[ptr];
                in_sop = (ptr == 0); in_eop = (ptr == plen - 1);
            end else begin
                in_valid = 0; in_sop = 0; in_eop = 0;
            end
            #1;
            if (out_valid && out_ready) begin stream[slen] = out_data; slen++; end
            if (in_valid && in_ready) ptr++;
            if (ptr == plen) begin idle++; if (idle > 30) break; end
        end
        in_valid = 0; in_sop = 0; in_eop = 0;
    endtask

    task automatic decode(input bit scr, input bit laps);
        logic [42:0] h;
        logic [7:0]  y, x;
        int i, clen;
        bit seen;
        h = '0;
        for (int j = 0; j < slen; j++) begin
            y = stream[j];
            for (int b = 7; b >= 0; b--) begin
                x[b] = scr ? (y[b] ^ h[42]) : y[b];
                h = {h[41:0], y[b]};
            end
            ds[j] = x;
        end
        nfr = 0; ra_cnt = 0; clen = 0; seen = 0; flen = 0; i = 0;
        while (i < slen) begin
            if (ds[i] == 8'h7E) begin
                if (seen && clen > 0) begin
                    if (nfr == 0) flen = clen;
                    nfr++;
                end
                seen = 1; clen = 0;
            end else if (seen) begin
                if (ds[i] == 8'h7D && i + 1 < slen) begin
                    if (laps && cfg_ra_pair[15:8] == 8'h7D && ds[i+1] == cfg_ra_pair[7:0]) begin
                        ra_cnt++;
                    end else begin
                        if (nfr == 0 && clen < 512) fb[clen] = ds[i+1] ^ 8'h20;
                        clen++;
                    end
                    i++;
                end else begin
                    if (nfr == 0 && clen < 512) fb[clen] = ds[i];
                    clen++;
                end
            end
            i++;
        end
    endtask

    function automatic logic [7:0] gen_byte(int kind, int idx, logic [7:0] seed);
        logic [7:0] r;
        case (kind)
            1: return 8'h7E;
            2: return 8'h7D;
            3: return idx[0] ? 8'h7D : 8'h7E;
            4: return 8'(idx) + seed;
            default: begin
                r = seed;
                for (int k = 0; k <= idx; k++) r = r * 8'd37 + 8'd11;
                return r;
            end
        endcase
    endfunction

    initial begin
        cfg_hdr_en = 0; cfg_ext_fcs = 0; cfg_laps_en = 0; cfg_scr_en = 0;
        cfg_addr = 8'hFF; cfg_ctl = 8'h03; cfg_ra_pair = 16'h7DDD;

        // ---------------- table-driven round trips ----------------
        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] e;
            int n, mism_h, mism_p, off;
            logic [31:0] crc;
            e = VEC[v];
            plen        = int'(e[7:0]);
            cfg_hdr_en  = e[11];
            cfg_ext_fcs = e[12];
            cfg_laps_en = e[13];
            cfg_scr_en  = e[14];
            cfg_addr    = e[24] ? 8'h7D : 8'hFF;
            cfg_ctl     = e[25] ? 8'h7E : 8'h03;
            cfg_ra_pair = 16'h7DDD;
            for (int k = 0; k < plen; k++) pkt[k] = gen_byte(int'(e[10:8]), k, e[31:24]);
            do_reset();
            run_packet(e[16], e[15]);
            decode(e[14], e[13]);

            n = 0; crc = 32'hFFFFFFFF;
            if (e[11]) begin expc[0] = cfg_addr; expc[1] = cfg_ctl; n = 2; end
            for (int k = 0; k < plen; k++) begin expc[n] = pkt[k]; n++; end
            for (int k = 0; k < n; k++) crc = crc_b(crc, expc[k]);
            crc = ~crc;
            if (!e[12]) for (int k = 0; k < 4; k++) begin expc[n] = crc[8*k +: 8]; n++; end

            chk(nfr == 1, "R7 frame count", nfr, 1);
            chk(flen == n, e[12] ? "R4 frame length" : "R3 frame length", flen, n);
            mism_h = 0; mism_p = 0;
            off = e[11] ? 2 : 0;
            if (flen == n) begin
                for (int k = 0; k < off; k++) if (fb[k] != expc[k]) mism_h++;
                for (int k = off; k < off + plen; k++) if (fb[k] != expc[k]) mism_p++;
            end
            if (e[11]) chk(mism_h == 0, "R2 header octets", mism_h, 0);
            chk(mism_p == 0, "R5 payload recovered", mism_p, 0);
            if (!e[12] && flen == n) begin
                int mf;
                mf = 0;
                for (int k = off + plen; k < n; k++) if (fb[k] != expc[k]) mf++;
                chk(mf == 0, "R3 fcs octets", mf, 0);
            end
            if (e[13] && e[15]) chk(ra_cnt > 0, "R8 rate-adaptation seen", ra_cnt, 1);
            if (!e[13])         chk(ra_cnt == 0, "R10 no rate-adaptation", ra_cnt, 0);
            if (e[14]) begin
                int diff;
                diff = 0;
                for (int k = 0; k < slen; k++) if (stream[k] != ds[k]) diff++;
                chk(diff > 0, "R11 scrambled line differs", diff, 1);
            end
        end

        // ---------------- R1: reset and idle ----------------
        cfg_hdr_en = 0; cfg_ext_fcs = 1; cfg_laps_en = 0; cfg_scr_en = 0;
        cfg_ra_pair = 16'h7DDD;
        do_reset();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); out_ready = 1; #1;
            chk(out_valid && out_data == 8'h7E, "R1 idle flag", int'(out_data), 8'h7E);
            chk(!in_ready, "R1 ready low at idle", int'(in_ready), 0);
        end

        // ---------------- R5/R6/R12: escape pair timing ----------------
        do_reset();
        @(negedge clk); out_ready = 1; in_valid = 1; in_sop = 1; in_eop = 1; in_data = 8'h7E; #1;
        chk(out_data == 8'h7E && !in_ready, "R7 opening flag", int'(out_data), 8'h7E);
        @(negedge clk); #1;
        chk(out_data == 8'h7D, "R5 escape lead", int'(out_data), 8'h7D);
        chk(in_ready, "R6 ready with lead octet", int'(in_ready), 1);
        @(negedge clk); in_valid = 0; in_sop = 0; in_eop = 0; out_ready = 0; #1;
        chk(out_valid && out_data == 8'h5E, "R5 escape tail", int'(out_data), 8'h5E);
        chk(!in_ready, "R6 ready low with tail octet", int'(in_ready), 0);
        @(negedge clk); #1;
        chk(out_valid && out_data == 8'h5E, "R12 held under backpressure", int'(out_data), 8'h5E);
        @(negedge clk); out_ready = 1; #1;
        chk(out_data == 8'h5E, "R12 tail after release", int'(out_data), 8'h5E);
        @(negedge clk); #1;
        chk(out_data == 8'h7E, "R7 closing flag", int'(out_data), 8'h7E);

        // ---------------- R8/R9: custom rate-adaptation pair ----------------
        cfg_laps_en = 1; cfg_ra_pair = 16'h7DCC;
        do_reset();
        @(negedge clk); out_ready = 1; in_valid = 1; in_sop = 1; in_eop = 0; in_data = 8'h11; #1;
        @(negedge clk); #1;
        chk(out_data == 8'h11 && in_ready, "R6 plain octet taken", int'(out_data), 8'h11);
        @(negedge clk); in_valid = 0; in_sop = 0; #1;
        chk(out_valid && out_data == 8'h7D, "R8 pair high octet", int'(out_data), 8'h7D);
        @(negedge clk); in_valid = 1; in_eop = 1; in_data = 8'h22; #1;
        chk(out_data == 8'hCC, "R9 pair low octet", int'(out_data), 8'hCC);
        chk(!in_ready, "R8 no input during pair", int'(in_ready), 0);
        @(negedge clk); #1;
        chk(out_data == 8'h22 && in_ready, "R8 data resumes", int'(out_data), 8'h22);
        @(negedge clk); in_valid = 0; in_eop = 0; #1;
        chk(out_data == 8'h7E, "R7 flag after frame", int'(out_data), 8'h7E);

        // ---------------- R10: HDLC underrun stalls ----------------
        cfg_laps_en = 0; cfg_ra_pair = 16'h7DDD;
        do_reset();
        @(negedge clk); out_ready = 1; in_valid = 1; in_sop = 1; in_eop = 0; in_data = 8'h11; #1;
        @(negedge clk); #1;
        @(negedge clk); in_valid = 0; in_sop = 0; #1;
        chk(!out_valid, "R10 stall on underrun", int'(out_valid), 0);
        @(negedge clk); in_valid = 1; in_eop = 1; in_data = 8'h22; #1;
        chk(out_valid && out_data == 8'h22, "R10 resume after underrun", int'(out_data), 8'h22);
        @(negedge clk); in_valid = 0; in_eop = 0; #1;

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule